// File: doc/BRIEF.md
# Congestion-aware DVS directive governor

This block sits at one router output port and chooses the voltage/frequency level that the outgoing link should move toward. Levels are indices 0 to 9: index 0 is the fastest setting and index 9 is the slowest. A higher index is a "down" step, which saves power. A lower index is an "up" step, which adds speed. At the start of every sampling window, software loads two 4-bit directives. The intermediate directive is the slowest level the link may reach in that window. The final directive is the level the link must be back at when the window ends.

Each cycle the block adds the current output-buffer occupancy to a moving sum taken over the last 300 router cycles. It compares that average against three thresholds: low, high and top. The result decides whether a planned down step is taken, deferred by a fixed retry interval, or replaced by an up step. The block issues single-level requests to the link ramp sequencer. After each request it waits one combined voltage plus frequency step delay of 120 cycles before it issues the next. It starts the ramp back up to the final level early enough to reach that level by the window boundary.

Top module: `dvs_governor`

## Requirements
- R1: After reset the requested level `tgt_lvl_o` is 0 and `step_o` is 0.
- R2: A one-cycle `win_start_i` loads `dir_inter_i` and `dir_final_i` (4-bit level indices, 0 fastest, 9 slowest) and the window length `win_len_i`, and clears the retry state. No step is issued on that edge. The new directives govern from the next cycle.
- R3: The occupancy metric is the sum of `occ_i` over the last 300 cycles, divided by `BUF_DEPTH*300`. Thresholds are unsigned fixed-point with 8 fraction bits (256 = 1.0). The metric exceeds threshold t when sum*256 > t*BUF_DEPTH*300, and it is below t when sum*256 < t*BUF_DEPTH*300. A decision at an edge uses the sum of the samples taken at the 300 earlier edges.
- R4: Each request moves the level by exactly one, pulses `step_o` for one cycle, and comes at least 120 cycles after the previous request.
- R5: A down step is taken only when all of the following hold. The level is below the intermediate directive. The remaining window time is at least 120*(1+max(L+1-F,0)), where L is the current level and F is the final directive. No congestion rule or retry blocks the step. The level never goes above the intermediate directive through a down step.
- R6: If the metric is above the high threshold when a down step is due, the step is deferred for 240 cycles. After that interval, a down step happens only if the metric is below the low threshold. Otherwise another 240-cycle interval starts.
- R7: While the metric is above the top threshold, no down step is taken. If the link is not already at level 0 and no step is in progress, the level moves up by one.
- R8: If the level is slower than the intermediate directive, the block steps up toward that directive.
- R9: When the level is slower than the final directive and the remaining window time is at most 120*(L-F), the block steps up, so that the final level is reached by the boundary.
- R10: If the final level was not reached when a new window starts, the block keeps stepping up toward that old final level before any down step of the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Router clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| win_start_i | input | 1 | Window-start strobe, loads directives and length |
| win_len_i | input | WIN_W | Window length in cycles |
| dir_inter_i | input | 4 | Intermediate directive (slowest allowed level) |
| dir_final_i | input | 4 | Final directive (level at window end) |
| occ_i | input | OCC_W | Occupied output-buffer slots this cycle |
| thr_low_i | input | FRAC_W+1 | Low threshold, fixed point |
| thr_high_i | input | FRAC_W+1 | High threshold, fixed point |
| thr_top_i | input | FRAC_W+1 | Top threshold, fixed point |
| tgt_lvl_o | output | 4 | Requested link level |
| step_o | output | 1 | One-cycle strobe on each level request |

## Verification
Every internal state of this block shows up only at `tgt_lvl_o` and `step_o`. A fault therefore appears as a step that moves to the wrong cycle or to the wrong level. A moving sum that drops or keeps one sample moves a threshold crossing, and with it the first up step under congestion, by a cycle or more. A wrong retry length or a lost deferral flag lets a down step through early, or holds it back, within one 240-cycle interval. A wrong ramp-up or carry computation leaves the wrong level at a window boundary. Comparing both outputs against an independent model on every clock exposes each of these at the first cycle where they diverge.

// File: rtl/dvs_gov_pkg.sv
package dvs_gov_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef enum logic [1:0] {ACT_HOLD, ACT_UP, ACT_DN} act_e;
endpackage

// File: rtl/dvs_occ_meter.sv
module dvs_occ_meter #(
  parameter int BUF_DEPTH = 8,
  parameter int AVG_LEN   = 300,
  parameter int FRAC_W    = 8,
  localparam int OCC_W    = $clog2(BUF_DEPTH + 1),
  localparam int THR_W    = FRAC_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [THR_W-1:0] thr_low_i,
  input  logic [THR_W-1:0] thr_high_i,
  input  logic [THR_W-1:0] thr_top_i,
  output logic             below_low_o,
  output logic             above_high_o,
  output logic             above_top_o
);
  localparam int SCALE = BUF_DEPTH * AVG_LEN;
  localparam int SUM_W = $clog2(SCALE + 1);
  localparam int PTR_W = $clog2(AVG_LEN);
  localparam int CMP_W = SUM_W + FRAC_W + 2;

  logic [OCC_W-1:0] hist_q [AVG_LEN];
  logic [PTR_W-1:0] ptr_q;
  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < AVG_LEN; i++) hist_q[i] <= '0;
      ptr_q <= '0;
      sum_q <= '0;
    end else begin
      hist_q[ptr_q] <= occ_i;
      ptr_q <= (ptr_q == PTR_W'(AVG_LEN - 1)) ? '0 : ptr_q + 1'b1;
      sum_q <= sum_q + SUM_W'(occ_i) - SUM_W'(hist_q[ptr_q]);
    end
  end

  // metric > thr  <=>  sum * 2^FRAC_W > thr * depth * window
  logic [CMP_W-1:0] sum_x, low_x, high_x, top_x;
  assign sum_x  = CMP_W'(sum_q) << FRAC_W;
  assign low_x  = CMP_W'(thr_low_i)  * CMP_W'(SCALE);
  assign high_x = CMP_W'(thr_high_i) * CMP_W'(SCALE);
  assign top_x  = CMP_W'(thr_top_i)  * CMP_W'(SCALE);

  assign below_low_o  = sum_x < low_x;
  assign above_high_o = sum_x > high_x;
  assign above_top_o  = sum_x > top_x;

  AST_SUM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_q <= SUM_W'(SCALE)); // R3
endmodule

// File: rtl/dvs_dir_window.sv
module dvs_dir_window
  import dvs_gov_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_start_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  lvl_t             dir_inter_i,
  input  lvl_t             dir_final_i,
  output lvl_t             inter_o,
  output lvl_t             final_o,
  output logic [WIN_W-1:0] rem_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inter_o <= '0;
      final_o <= '0;
      rem_o   <= '0;
    end else if (win_start_i) begin
      inter_o <= dir_inter_i;
      final_o <= dir_final_i;
      rem_o   <= win_len_i;
    end else if (rem_o != '0) begin
      rem_o <= rem_o - 1'b1;
    end
  end

  AST_REM_COUNTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_start_i && rem_o != '0 |=> rem_o == $past(rem_o) - 1'b1); // R5
endmodule

// File: rtl/dvs_step_ctrl.sv
module dvs_step_ctrl
  import dvs_gov_pkg::*;
#(
  parameter int WIN_W    = 16,
  parameter int STEP_DLY = 120
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_start_i,
  input  lvl_t             inter_i,
  input  lvl_t             fin_i,
  input  logic [WIN_W-1:0] rem_i,
  input  logic             below_low_i,
  input  logic             above_high_i,
  input  logic             above_top_i,
  output lvl_t             lvl_o,
  output logic             step_o
);
  localparam int RETRY_LEN = 2 * STEP_DLY;
  localparam int BUSY_W    = $clog2(STEP_DLY + 1);
  localparam int RET_W     = $clog2(RETRY_LEN + 1);

  lvl_t              lvl_q, carry_lvl_q;
  logic [BUSY_W-1:0] busy_q;
  logic [RET_W-1:0]  retry_q;
  logic              defer_q, carry_q;

  logic              carry_act, ramp_up, dn_ok, retry_start;
  logic [WIN_W-1:0]  up_gap, dn_need;
  logic [LVL_W:0]    nxt_lvl, dn_span;
  act_e              act;

  assign carry_act = carry_q && (lvl_q > carry_lvl_q);
  assign up_gap    = (lvl_q > fin_i) ? WIN_W'(STEP_DLY) * WIN_W'(lvl_q - fin_i) : '0;
  assign ramp_up   = (lvl_q > fin_i) && (rem_i <= up_gap);
  assign nxt_lvl   = {1'b0, lvl_q} + 1'b1;
  assign dn_span   = (nxt_lvl > {1'b0, fin_i}) ? nxt_lvl - {1'b0, fin_i} : '0;
  assign dn_need   = WIN_W'(STEP_DLY) * (WIN_W'(dn_span) + WIN_W'(1));
  assign dn_ok     = (lvl_q < inter_i) && (rem_i >= dn_need);

  always_comb begin
    act         = ACT_HOLD;
    retry_start = 1'b0;
    if (win_start_i || busy_q != '0) begin
      act = ACT_HOLD;
    end else if (above_top_i) begin
      if (lvl_q != '0) act = ACT_UP;
    end else if (carry_act || lvl_q > inter_i || ramp_up) begin
      act = ACT_UP;
    end else if (dn_ok && retry_q == '0) begin
      if (defer_q) begin
        if (below_low_i) act = ACT_DN;
        else             retry_start = 1'b1;
      end else if (above_high_i) begin
        retry_start = 1'b1;
      end else begin
        act = ACT_DN;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q       <= '0;
      step_o      <= 1'b0;
      busy_q      <= '0;
      retry_q     <= '0;
      defer_q     <= 1'b0;
      carry_q     <= 1'b0;
      carry_lvl_q <= '0;
    end else begin
      step_o <= (act != ACT_HOLD);
      case (act)
        ACT_UP:  lvl_q <= lvl_q - 1'b1;
        ACT_DN:  lvl_q <= lvl_q + 1'b1;
        default: lvl_q <= lvl_q;
      endcase
      if (act != ACT_HOLD) busy_q <= BUSY_W'(STEP_DLY - 1);
      else if (busy_q != '0) busy_q <= busy_q - 1'b1;

      if (win_start_i)         retry_q <= '0;
      else if (retry_start)    retry_q <= RET_W'(RETRY_LEN);
      else if (retry_q != '0)  retry_q <= retry_q - 1'b1;

      if (win_start_i)         defer_q <= 1'b0;
      else if (retry_start)    defer_q <= 1'b1;
      else if (act == ACT_DN)  defer_q <= 1'b0;

      if (win_start_i) begin
        carry_q     <= lvl_q > fin_i;
        carry_lvl_q <= fin_i;
      end else if (carry_q && lvl_q <= carry_lvl_q) begin
        carry_q <= 1'b0;
      end
    end
  end

  assign lvl_o = lvl_q;

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q != '0 |=> $stable(lvl_q)); // R4
  AST_DN_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q > $past(lvl_q) |-> lvl_q <= inter_i); // R5
  AST_RETRY_NO_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_q != '0 |=> lvl_q <= $past(lvl_q)); // R6
  AST_TOP_NO_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    above_top_i |=> lvl_q <= $past(lvl_q)); // R7
endmodule

// File: rtl/dvs_governor.sv
module dvs_governor
  import dvs_gov_pkg::*;
#(
  parameter int BUF_DEPTH = 8,
  parameter int AVG_LEN   = 300,
  parameter int FRAC_W    = 8,
  parameter int STEP_DLY  = 120,
  parameter int WIN_W     = 16,
  localparam int OCC_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_start_i,
  input  logic [WIN_W-1:0]  win_len_i,
  input  logic [3:0]        dir_inter_i,
  input  logic [3:0]        dir_final_i,
  input  logic [OCC_W-1:0]  occ_i,
  input  logic [FRAC_W:0]   thr_low_i,
  input  logic [FRAC_W:0]   thr_high_i,
  input  logic [FRAC_W:0]   thr_top_i,
  output logic [3:0]        tgt_lvl_o,
  output logic              step_o
);
  logic             below_low, above_high, above_top;
  lvl_t             inter, fin, lvl;
  logic [WIN_W-1:0] rem;

  dvs_occ_meter #(.BUF_DEPTH(BUF_DEPTH), .AVG_LEN(AVG_LEN), .FRAC_W(FRAC_W)) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .occ_i(occ_i),
    .thr_low_i(thr_low_i), .thr_high_i(thr_high_i), .thr_top_i(thr_top_i),
    .below_low_o(below_low), .above_high_o(above_high), .above_top_o(above_top));

  dvs_dir_window #(.WIN_W(WIN_W)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_start_i(win_start_i), .win_len_i(win_len_i),
    .dir_inter_i(dir_inter_i), .dir_final_i(dir_final_i),
    .inter_o(inter), .final_o(fin), .rem_o(rem));

  dvs_step_ctrl #(.WIN_W(WIN_W), .STEP_DLY(STEP_DLY)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_start_i(win_start_i),
    .inter_i(inter), .fin_i(fin), .rem_i(rem),
    .below_low_i(below_low), .above_high_i(above_high), .above_top_i(above_top),
    .lvl_o(lvl), .step_o(step_o));

  assign tgt_lvl_o = lvl;

  AST_ONE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (tgt_lvl_o == $past(tgt_lvl_o) + 4'd1) || (tgt_lvl_o + 4'd1 == $past(tgt_lvl_o))); // R4
endmodule

// File: tb/dvs_governor_tb.sv
`timescale 1ns/1ps
module dvs_governor_tb;
  localparam int DEPTH = 8;
  localparam int AVG   = 300;
  localparam int STEP  = 120;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        win_start_i = 1'b0;
  logic [15:0] win_len_i = '0;
  logic [3:0]  dir_inter_i = '0, dir_final_i = '0;
  logic [3:0]  occ_i = '0;
  logic [8:0]  thr_low_i = 9'd64, thr_high_i = 9'd128, thr_top_i = 9'd192;
  logic [3:0]  tgt_lvl_o;
  logic        step_o;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #2.5 clk_i = ~clk_i;

  dvs_governor u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_start_i(win_start_i), .win_len_i(win_len_i),
    .dir_inter_i(dir_inter_i), .dir_final_i(dir_final_i), .occ_i(occ_i),
    .thr_low_i(thr_low_i), .thr_high_i(thr_high_i), .thr_top_i(thr_top_i),
    .tgt_lvl_o(tgt_lvl_o), .step_o(step_o));

  // behavioural reference
  int m_lvl = 0, m_step = 0, m_busy = 0, m_retry = 0, m_defer = 0;
  int m_carry = 0, m_clvl = 0, m_inter = 0, m_fin = 0, m_rem = 0, m_sum = 0;
  int hist[$];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_lvl = 0; m_step = 0; m_busy = 0; m_retry = 0; m_defer = 0;
      m_carry = 0; m_clvl = 0; m_inter = 0; m_fin = 0; m_rem = 0; m_sum = 0;
      hist.delete();
    end else begin
      int act, rs, scale, need, span;
      bit top, high, low, ramp, cact;
      act = 0; rs = 0; scale = DEPTH * AVG;
      top  = m_sum * 256 > int'(thr_top_i) * scale;
      high = m_sum * 256 > int'(thr_high_i) * scale;
      low  = m_sum * 256 < int'(thr_low_i) * scale;
      cact = (m_carry != 0) && m_lvl > m_clvl;
      ramp = m_lvl > m_fin && m_rem <= STEP * (m_lvl - m_fin);
      span = (m_lvl + 1 > m_fin) ? m_lvl + 1 - m_fin : 0;
      need = STEP * (1 + span);
      if (win_start_i || m_busy != 0) act = 0;
      else if (top) act = (m_lvl > 0) ? 1 : 0;
      else if (cact || m_lvl > m_inter || ramp) act = 1;
      else if (m_lvl < m_inter && m_rem >= need && m_retry == 0) begin
        if (m_defer != 0) begin
          if (low) act = 2; else rs = 1;
        end else if (high) rs = 1;
        else act = 2;
      end
      m_busy = (act != 0) ? STEP - 1 : (m_busy > 0 ? m_busy - 1 : 0);
      if (win_start_i) m_retry = 0;
      else if (rs != 0) m_retry = 2 * STEP;
      else if (m_retry > 0) m_retry--;
      if (win_start_i) m_defer = 0;
      else if (rs != 0) m_defer = 1;
      else if (act == 2) m_defer = 0;
      if (win_start_i) begin
        m_carry = (m_lvl > m_fin) ? 1 : 0; m_clvl = m_fin;
      end else if (m_carry != 0 && m_lvl <= m_clvl) m_carry = 0;
      if (act == 1) m_lvl--; else if (act == 2) m_lvl++;
      m_step = (act != 0) ? 1 : 0;
      if (win_start_i) begin
        m_inter = int'(dir_inter_i); m_fin = int'(dir_final_i); m_rem = int'(win_len_i);
      end else if (m_rem > 0) m_rem--;
      hist.push_back(int'(occ_i));
      m_sum += int'(occ_i);
      if (hist.size() > AVG) m_sum -= hist.pop_front();
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      checks++;
      if (int'(tgt_lvl_o) != m_lvl || int'(step_o) != m_step) begin
        errors++;
        $display("FAIL %s: lvl/step actual %0d/%0d expected %0d/%0d at %0t",
                 cur_req, tgt_lvl_o, step_o, m_lvl, m_step, $time);
      end
    end
  end

  task automatic spot(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic new_win(input int inter, input int fin, input int len);
    win_start_i = 1'b1; dir_inter_i = 4'(inter); dir_final_i = 4'(fin); win_len_i = 16'(len);
    @(negedge clk_i);
    win_start_i = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a, b;
    run(4);
    spot("R1", int'(tgt_lvl_o), 0);
    spot("R1", int'(step_o), 0);
    rst_ni = 1'b1;
    run(2);

    // R2 / R5 / R9: quiet buffer, step down to intermediate, ramp back to final
    cur_req = "R5"; occ_i = 4'd1;
    new_win(6, 2, 3000);
    spot("R2", int'(tgt_lvl_o), 0);
    spot("R2", int'(step_o), 0);
    run(1);
    spot("R2", int'(tgt_lvl_o), 1);
    run(1499);
    spot("R5", int'(tgt_lvl_o), 6);
    cur_req = "R9";
    run(1499);
    spot("R9", int'(tgt_lvl_o), 2);

    // R6: deferral under moderate congestion, resume below low
    cur_req = "R6"; occ_i = 4'd5;
    new_win(8, 8, 6000);
    run(1199);
    occ_i = 4'd3;
    run(300);
    a = int'(tgt_lvl_o);
    run(700);
    b = int'(tgt_lvl_o);
    spot("R6", b, a);
    occ_i = 4'd0;
    run(3800);
    spot("R6", int'(tgt_lvl_o), 8);

    // R3 / R7: heavy congestion, first up step at the exact crossing cycle
    cur_req = "R7"; occ_i = 4'd7;
    new_win(9, 9, 6000);
    run(257);
    spot("R3", int'(tgt_lvl_o), 9);
    run(1);
    spot("R3", int'(tgt_lvl_o), 8);
    run(2741);
    spot("R7", int'(tgt_lvl_o), 0);

    // R8: intermediate lowered below the current level
    cur_req = "R8"; occ_i = 4'd0;
    new_win(8, 8, 3000);
    run(2999);
    spot("R5", int'(tgt_lvl_o), 8);
    new_win(3, 3, 3000);
    run(699);
    spot("R8", int'(tgt_lvl_o), 3);
    run(2300);

    // R10: final level not reached, carried into the next window
    cur_req = "R10";
    new_win(9, 9, 3000);
    run(2999);
    spot("R10", int'(tgt_lvl_o), 9);
    new_win(9, 0, 300);
    run(299);
    spot("R9", int'(tgt_lvl_o), 6);
    new_win(9, 9, 3000);
    run(399);
    spot("R10", int'(tgt_lvl_o), 3);
    run(2600);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule